// File: doc/BRIEF.md
# Processor Sleep Mode Controller

This block decides when a small processor core stops and restarts. It has two ways into the low-power state. In the first, the pipeline sends an explicit request pulse from a wait-for-interrupt or wait-for-event instruction. In the second, entry is automatic: an exception return that lands back at base thread level puts the core to sleep when the sleep-after-handler control bit is set. While the core sleeps, the block drives a `sleeping` flag that lets the core clock be stopped. It also drives a `sleep_deep` flag, gated by a second control bit, which an external clock manager can use to shut down more of the system.

On the automatic path the stacked register context stays in memory. The block tells the exception unit to skip the unstack on entry, and to skip the restack when the next interrupt wakes the core. Waking does not prove that an exception occurred. A debug request or an event can also end sleep, so software must keep an idle loop.

The state machine has three states: `ST_RUN`, `ST_SLEEP_NOW` (explicit instruction entry) and `ST_SLEEP_EXIT` (automatic entry on return). Its transitions are:
- **T_ENTER_NOW**: `ST_RUN` to `ST_SLEEP_NOW`, on a wait-for-interrupt request, or on a wait-for-event request with the event latch clear.
- **T_ENTER_EXIT**: `ST_RUN` to `ST_SLEEP_EXIT`, on a return to base with the sleep-after-handler bit set.
- **T_WAKE_NOW**: `ST_SLEEP_NOW` to `ST_RUN`, on a pending interrupt, a debug request, or (only in wait-for-event mode) an event.
- **T_WAKE_EXIT**: `ST_SLEEP_EXIT` to `ST_RUN`, on a pending interrupt or a debug request.

Entry is refused when an interrupt is already pending in the same cycle as the request. All outputs are registered and change on the clock edge that samples their cause.

Top module: `slp_mode_ctrl`

## Requirements
- R1: After reset, `sleeping`, `sleep_deep`, `hold_unstack` and `hold_stack` are 0. Both control bits are 0: a sleep never raises `sleep_deep`, and a return to base does not sleep.
- R2: A `req_wfi` pulse sampled with `wake_irq` low sets `sleeping` after that edge. `sleeping` stays set until a wake cause is sampled.
- R3: A sleep request (`req_wfi`, `req_wfe`, or a return to base) sampled in the same cycle as `wake_irq` high does not set `sleeping`.
- R4: `wake_irq` sampled high while sleeping clears `sleeping` and `sleep_deep` after that edge.
- R5: `exc_ret` with `exc_ret_base`=1, sampled while the sleep-after-handler bit is 1, sets `sleeping`. On the same edge, `hold_unstack` goes high for exactly one cycle. The same return with `exc_ret_base`=0 does not sleep.
- R6: A wake by `wake_irq` from automatic-entry sleep raises `hold_stack` for exactly one cycle, on the same edge that clears `sleeping`.
- R7: `sleep_deep` equals `sleeping` AND the deep-sleep control bit, for both entry paths.
- R8: A `req_wfe` that finds the event latch set (or `evt_in` high in the same cycle) does not sleep, and it clears the latch. A later `req_wfe` then sleeps. The latch is set by `evt_in`.
- R9: Sleep entered by `req_wfe` ends when `evt_in` is sampled high. Sleep entered by `req_wfi` ignores `evt_in`.
- R10: `dbg_req` sampled high ends sleep from either state with `hold_stack` left at 0.
- R11: The control bits are written when `reg_wr_en`=1 and `reg_wr_addr`=4'h4. Data bit 1 is sleep-after-handler and data bit 2 is deep-sleep. Writes to any other address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wfi | input | 1 | Wait-for-interrupt request pulse |
| req_wfe | input | 1 | Wait-for-event request pulse |
| exc_ret | input | 1 | Exception return pulse |
| exc_ret_base | input | 1 | The return lands at base thread level |
| wake_irq | input | 1 | Pending interrupt |
| evt_in | input | 1 | Wake event |
| dbg_req | input | 1 | Debug wake request |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_addr | input | ADDR_W (4) | Write address |
| reg_wr_data | input | DATA_W (8) | Write data |
| sleeping | output | 1 | Core clock may be stopped |
| sleep_deep | output | 1 | Deeper sleep allowed (for the clock manager) |
| hold_unstack | output | 1 | Skip context unstack (one-cycle pulse) |
| hold_stack | output | 1 | Skip context stack on wake (one-cycle pulse) |

## Verification
The bench builds the block with its default parameters: a 4-bit address, an 8-bit data word, the control word at address 4, and the two bits at positions 1 and 2. With a 4-bit address, a write to a nearby address (3) can be shown to leave both bits unchanged. With both bits in one word, a single write can enable deep sleep and automatic entry together. Sleeps are then started through both entry paths and ended by interrupt, debug and event. Same-cycle collisions between a request and a pending interrupt or event are exercised as well.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_SLEEP_NOW  = 2'd1,
        ST_SLEEP_EXIT = 2'd2
    } slp_state_e;
endpackage

// File: rtl/slp_ctrl_regs.sv
module slp_ctrl_regs #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 4,
    parameter int SOE_POS   = 1,
    parameter int DEEP_POS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              soe_en,
    output logic              deep_en
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic hit;
    assign hit = wr_en && (wr_addr == CTRL_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soe_en  <= 1'b0;
            deep_en <= 1'b0;
        end else if (hit) begin
            soe_en  <= wr_data[SOE_POS];
            deep_en <= wr_data[DEEP_POS];
        end
    end

    // R11
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CTRL_A) |=> (soe_en == $past(wr_data[SOE_POS]) && deep_en == $past(wr_data[DEEP_POS])));

    // R11
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == CTRL_A) |=> ($stable(soe_en) && $stable(deep_en)));
endmodule

// File: rtl/slp_evt_latch.sv
module slp_evt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic latch_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            latch_q <= 1'b0;
        else if (clr_i)
            latch_q <= 1'b0;
        else if (set_i)
            latch_q <= 1'b1;
    end

    // R8
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !latch_q);

    // R8
    latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> latch_q);
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_wfi,
    input  logic req_wfe,
    input  logic exc_ret,
    input  logic exc_ret_base,
    input  logic wake_irq,
    input  logic evt_in,
    input  logic dbg_req,
    input  logic soe_en,
    input  logic deep_en,
    input  logic evt_latch,
    output logic evt_set,
    output logic evt_clr,
    output logic sleeping,
    output logic sleep_deep,
    output logic hold_unstack,
    output logic hold_stack
);
    slp_state_e state_q, state_d;
    logic       wfe_mode_q, wfe_mode_d;
    logic       exit_req, evt_seen;

    assign exit_req = exc_ret && exc_ret_base && soe_en;
    assign evt_seen = evt_latch || evt_in;

    // next state
    always_comb begin
        state_d    = state_q;
        wfe_mode_d = wfe_mode_q;
        evt_clr    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (req_wfe && !exit_req && !req_wfi && evt_seen)
                    evt_clr = 1'b1;
                if (!wake_irq) begin
                    if (exit_req) begin
                        state_d    = ST_SLEEP_EXIT;
                        wfe_mode_d = 1'b0;
                    end else if (req_wfi) begin
                        state_d    = ST_SLEEP_NOW;
                        wfe_mode_d = 1'b0;
                    end else if (req_wfe && !evt_seen) begin
                        state_d    = ST_SLEEP_NOW;
                        wfe_mode_d = 1'b1;
                    end
                end
            end
            ST_SLEEP_NOW: begin
                if (wake_irq || dbg_req || (wfe_mode_q && evt_in)) begin
                    state_d    = ST_RUN;
                    wfe_mode_d = 1'b0;
                end
            end
            ST_SLEEP_EXIT: begin
                if (wake_irq || dbg_req)
                    state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign evt_set = evt_in && !(state_q == ST_SLEEP_NOW && wfe_mode_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_RUN;
            wfe_mode_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            wfe_mode_q <= wfe_mode_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleeping     <= 1'b0;
            sleep_deep   <= 1'b0;
            hold_unstack <= 1'b0;
            hold_stack   <= 1'b0;
        end else begin
            sleeping     <= (state_d != ST_RUN);
            sleep_deep   <= (state_d != ST_RUN) && deep_en;
            hold_unstack <= (state_q == ST_RUN) && (state_d == ST_SLEEP_EXIT);
            hold_stack   <= (state_q == ST_SLEEP_EXIT) && (state_d == ST_RUN) && wake_irq;
        end
    end

    // R4
    wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && wake_irq) |=> (!sleeping && !sleep_deep));

    // R3
    no_entry_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wake_irq) |=> !sleeping);

    // R7
    deep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_deep |-> (sleeping && $past(deep_en)));

    // R6
    hold_stack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_stack |-> ($past(state_q) == ST_SLEEP_EXIT && !sleeping && $past(wake_irq)));

    // R5
    hold_unstack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_unstack |=> !hold_unstack);

    // R9
    wfi_ignores_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP_NOW && !wfe_mode_q && !wake_irq && !dbg_req) |=> sleeping);
endmodule

// File: rtl/slp_mode_ctrl.sv
module slp_mode_ctrl #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 4,
    parameter int SOE_POS   = 1,
    parameter int DEEP_POS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wfi,
    input  logic              req_wfe,
    input  logic              exc_ret,
    input  logic              exc_ret_base,
    input  logic              wake_irq,
    input  logic              evt_in,
    input  logic              dbg_req,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic              sleeping,
    output logic              sleep_deep,
    output logic              hold_unstack,
    output logic              hold_stack
);
    logic soe_en, deep_en, evt_latch, evt_set, evt_clr;

    slp_ctrl_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
        .SOE_POS(SOE_POS), .DEEP_POS(DEEP_POS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .soe_en(soe_en), .deep_en(deep_en)
    );

    slp_evt_latch u_evt (
        .clk(clk), .rst_n(rst_n),
        .set_i(evt_set), .clr_i(evt_clr), .latch_q(evt_latch)
    );

    slp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_wfi(req_wfi), .req_wfe(req_wfe),
        .exc_ret(exc_ret), .exc_ret_base(exc_ret_base),
        .wake_irq(wake_irq), .evt_in(evt_in), .dbg_req(dbg_req),
        .soe_en(soe_en), .deep_en(deep_en), .evt_latch(evt_latch),
        .evt_set(evt_set), .evt_clr(evt_clr),
        .sleeping(sleeping), .sleep_deep(sleep_deep),
        .hold_unstack(hold_unstack), .hold_stack(hold_stack)
    );

    // R10
    dbg_no_restack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && dbg_req && !wake_irq) |=> (!sleeping && !hold_stack));
endmodule

// File: tb/slp_mode_ctrl_tb.sv
module slp_mode_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  sl;
        logic  dp;
        logic  hu;
        logic  hs;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_wfi = 0, req_wfe = 0, exc_ret = 0, exc_ret_base = 0;
    logic       wake_irq = 0, evt_in = 0, dbg_req = 0;
    logic       reg_wr_en = 0;
    logic [3:0] reg_wr_addr = '0;
    logic [7:0] reg_wr_data = '0;
    logic       sleeping, sleep_deep, hold_unstack, hold_stack;

    int   total = 0;
    int   bad = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    slp_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_wfi(req_wfi), .req_wfe(req_wfe),
        .exc_ret(exc_ret), .exc_ret_base(exc_ret_base),
        .wake_irq(wake_irq), .evt_in(evt_in), .dbg_req(dbg_req),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .sleeping(sleeping), .sleep_deep(sleep_deep),
        .hold_unstack(hold_unstack), .hold_stack(hold_stack)
    );

    task automatic compare(input exp_t e);
        total++;
        if ({sleeping, sleep_deep, hold_unstack, hold_stack} !== {e.sl, e.dp, e.hu, e.hs}) begin
            bad++;
            $display("FAIL %s: actual sl/dp/hu/hs=%b%b%b%b expected=%b%b%b%b",
                     e.tag, sleeping, sleep_deep, hold_unstack, hold_stack,
                     e.sl, e.dp, e.hu, e.hs);
        end
    endtask

    // monitor: pops one expected item per edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    // driver: one cycle of stimulus plus its expected result
    task automatic step(input logic wfi, wfe, er, erb, irq, evt, dbg,
                        input logic sl, dp, hu, hs, input string tag);
        exp_t e;
        @(negedge clk);
        req_wfi = wfi; req_wfe = wfe; exc_ret = er; exc_ret_base = erb;
        wake_irq = irq; evt_in = evt; dbg_req = dbg;
        reg_wr_en = 1'b0;
        e.sl = sl; e.dp = dp; e.hu = hu; e.hs = hs; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wreg(input logic [3:0] a, input logic [7:0] d,
                        input logic sl, dp, input string tag);
        exp_t e;
        @(negedge clk);
        req_wfi = 0; req_wfe = 0; exc_ret = 0; exc_ret_base = 0;
        wake_irq = 0; evt_in = 0; dbg_req = 0;
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        e.sl = sl; e.dp = dp; e.hu = 0; e.hs = 0; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        total++;
        if ({sleeping, sleep_deep, hold_unstack, hold_stack} !== 4'b0000) begin
            bad++;
            $display("FAIL R1 reset: actual=%b%b%b%b expected=0000",
                     sleeping, sleep_deep, hold_unstack, hold_stack);
        end
        //        wfi wfe er erb irq evt dbg   sl dp hu hs
        step(1,0,0,0,0,0,0, 1,0,0,0, "R2 wfi enters, R1 deep bit zero");
        step(0,0,0,0,0,0,0, 1,0,0,0, "R2 stays asleep");
        step(0,0,0,0,0,1,0, 1,0,0,0, "R9 wfi ignores event");
        step(0,0,0,0,1,0,0, 0,0,0,0, "R4 irq wakes");
        step(0,0,0,0,0,0,0, 0,0,0,0, "R4 running");
        step(1,0,0,0,1,0,0, 0,0,0,0, "R3 wfi with pending irq");
        step(0,0,1,1,0,0,0, 0,0,0,0, "R1 return no sleep with bit clear");
        wreg(4'h4, 8'h02, 0, 0, "R11 write sleep-after-handler");
        step(0,0,1,1,0,0,0, 1,0,1,0, "R5 auto entry");
        step(0,0,0,0,0,0,0, 1,0,0,0, "R5 unstack pulse ends");
        step(0,0,0,0,1,0,0, 0,0,0,1, "R6 restack skip on wake");
        step(0,0,0,0,0,0,0, 0,0,0,0, "R6 pulse ends");
        step(0,0,1,0,0,0,0, 0,0,0,0, "R5 non-base return");
        step(0,0,1,1,1,0,0, 0,0,0,0, "R3 auto entry with pending irq");
        wreg(4'h3, 8'h06, 0, 0, "R11 other address");
        step(1,0,0,0,0,0,0, 1,0,0,0, "R11 deep unchanged by other address");
        step(0,0,0,0,1,0,0, 0,0,0,0, "R4 wake");
        wreg(4'h4, 8'h06, 0, 0, "R11 write both bits");
        step(1,0,0,0,0,0,0, 1,1,0,0, "R7 deep with wfi");
        step(0,0,0,0,0,0,1, 0,0,0,0, "R10 debug wakes sleep-now");
        step(0,0,1,1,0,0,0, 1,1,1,0, "R7 deep with auto entry");
        step(0,0,0,0,0,0,1, 0,0,0,0, "R10 debug wakes auto sleep, no restack");
        wreg(4'h4, 8'h00, 0, 0, "R11 clear bits");
        step(0,0,0,0,0,1,0, 0,0,0,0, "R8 set event latch");
        step(0,1,0,0,0,0,0, 0,0,0,0, "R8 wfe consumes latch");
        step(0,1,0,0,0,0,0, 1,0,0,0, "R8 wfe sleeps after clear");
        step(0,0,0,0,0,1,0, 0,0,0,0, "R9 event wakes wfe sleep");
        step(0,1,0,0,0,1,0, 0,0,0,0, "R8 wfe with same-cycle event");
        step(0,1,0,0,1,0,0, 0,0,0,0, "R3 wfe with pending irq");
        step(0,0,0,0,0,0,0, 0,0,0,0, "idle");
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule